// File: doc/BRIEF.md
# Period-Reset Up Counter with Compare Trigger

This block is a 16-bit up counter with a prescaler, a sticky overflow flag and an interrupt output, plus a compare unit. Each increment is produced from a number of input ticks that a 2-bit field selects. Software can load the count at any time and can clear the overflow flag.

When the compare mode field holds the special-event code, the compare value works as a period register. The first cycle in which the count equals the compare value starts a clear of the count. That same arrival sends a one-cycle start pulse to an external converter, provided the converter is enabled. A clear caused by a match never raises the overflow flag. A count write that lands together with such a clear wins.

Top module: `period_timer`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it falls, the count, overflow flag, interrupt and start pulse are all 0.
- R2: Each prescaled increment raises the count by exactly one, and an increment at 16'hFFFF wraps the count to 16'h0000.
- R3: A wrap sets the overflow flag on the same clock edge that the count becomes 0. The flag stays set until a flag-clear request arrives. If a wrap and a clear request fall in the same cycle, the flag ends up set.
- R4: The interrupt output is a register that holds the overflow flag ANDed with the interrupt enable. A change of the enable therefore shows at the output one edge later.
- R5: Prescale code 2'b00, 2'b01, 2'b10 and 2'b11 needs 1, 2, 4 and 8 qualified ticks per increment. A write to the count restarts the prescale phase.
- R6: While the run input is 0, ticks do not move the count, but count writes and flag clears still take effect.
- R7: With the compare mode at 4'b1011, the first cycle in which the count equals the compare value clears the count to 0 at the next edge. This clear does not set the overflow flag.
- R8: With any other compare mode value, a count that equals the compare value does not clear the count.
- R9: In mode 4'b1011 each arrival of the count at the compare value gives exactly one one-cycle start pulse. The pulse appears on the edge that clears the count, and only if the converter enable was high. A count that stays at the compare value does not retrigger.
- R10: A count write in the same cycle as a match-triggered clear loads the written value instead of 0. The start pulse is still issued.
- R11: A count write loads its value at the next edge and takes priority over an increment in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-enable tick, one per clock when high |
| run_i | input | 1 | 1 lets ticks advance the counter |
| psc_sel_i | input | 2 | Prescale select (ticks per increment 1/2/4/8) |
| wr_en_i | input | 1 | Load request for the count |
| wr_data_i | input | 16 | Value to load into the count |
| cmp_val_i | input | 16 | Compare / period value |
| cmp_mode_i | input | 4 | Compare mode; 4'b1011 enables period clear |
| conv_en_i | input | 1 | Converter enable qualifying the start pulse |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the overflow flag |
| count_o | output | 16 | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Registered interrupt request |
| conv_start_o | output | 1 | One-cycle start pulse for the converter |

## Verification
The two functions that can meet in one cycle are the match-triggered clear and a software load of the count. The bench runs the counter in special-event mode until the count sits on the compare value. It then asserts a write in exactly that cycle and expects the written value, not zero, at the next edge, with the start pulse still present. The flag has a similar meeting point: a wrap and a flag-clear request can arrive together. The bench makes them coincide and requires the flag to end up set.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 16;
  localparam int PSC_W   = 2;
  localparam int MODE_W  = 4;
  localparam logic [MODE_W-1:0] MODE_PERIOD_CLR = 4'b1011;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] sel_i,
  output logic             inc_o
);
  // widest divider is 2**(2**PSC_W - 1); phase counter needs 2**PSC_W - 1 bits
  localparam int PH_W = (1 << PSC_W) - 1;

  logic [PH_W-1:0] phase_q;
  logic [PH_W:0]   span;
  logic [PH_W-1:0] last;
  logic            adv;

  always_comb begin
    span = (PH_W+1)'(1) << sel_i;
    last = PH_W'(span - 1'b1);
  end

  assign adv   = tick_i & run_i;
  assign inc_o = adv & ~restart_i & (phase_q == last);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      phase_q <= '0;
    end else if (adv) begin
      if (phase_q == last) phase_q <= '0;
      else                 phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // load beats match-clear beats increment
  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_i)  cnt_q <= wr_data_i;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o  = inc_i & ~wr_i & ~clr_i & (&cnt_q);
  assign count_o = cnt_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare #(
  parameter int W      = 16,
  parameter int MODE_W = 4,
  parameter logic [MODE_W-1:0] CLR_MODE = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [W-1:0]      count_i,
  input  logic [W-1:0]      cmp_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              conv_en_i,
  output logic              clr_o,
  output logic              start_o
);
  logic equal, equal_q, arrive, start_q;

  assign equal  = (count_i == cmp_i);
  assign arrive = equal & ~equal_q;
  assign clr_o  = arrive & (mode_i == CLR_MODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      equal_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      equal_q <= equal;
      start_q <= clr_o & conv_en_i;
    end
  end

  assign start_o = start_q;
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q, flag_d;

  // a new event is never lost to a simultaneous clear
  assign flag_d = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/period_timer.sv
module period_timer
  import tmr_pkg::*;
#(
  parameter int W      = CNT_W,
  parameter int PW     = PSC_W,
  parameter int MW     = MODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic [PW-1:0] psc_sel_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [W-1:0]  cmp_val_i,
  input  logic [MW-1:0] cmp_mode_i,
  input  logic          conv_en_i,
  input  logic          irq_en_i,
  input  logic          flag_clr_i,
  output logic [W-1:0]  count_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          conv_start_o
);
  logic inc, match_clr, wrap;

  tmr_prescaler #(.PSC_W(PW)) u_psc (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i),
    .restart_i(wr_en_i), .sel_i(psc_sel_i), .inc_o(inc)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .wr_i(wr_en_i), .wr_data_i(wr_data_i),
    .clr_i(match_clr), .inc_i(inc), .count_o(count_o), .wrap_o(wrap)
  );

  tmr_compare #(.W(W), .MODE_W(MW), .CLR_MODE(MODE_PERIOD_CLR)) u_cmp (
    .clk(clk), .rst(rst), .count_i(count_o), .cmp_i(cmp_val_i),
    .mode_i(cmp_mode_i), .conv_en_i(conv_en_i),
    .clr_o(match_clr), .start_o(conv_start_o)
  );

  tmr_flag u_flg (
    .clk(clk), .rst(rst), .set_i(wrap), .clr_i(flag_clr_i),
    .irq_en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int W  = 16,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          run_i,
  input logic          wr_en_i,
  input logic [W-1:0]  wr_data_i,
  input logic [W-1:0]  cmp_val_i,
  input logic [MW-1:0] cmp_mode_i,
  input logic          conv_en_i,
  input logic [W-1:0]  count_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          conv_start_o
);
  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en_i) && $past(count_o) == {W{1'b1}} && count_o == '0)
    |-> flag_o);

  p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);

  p_stopped_holds_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(run_i) && !$past(wr_en_i) && $past(cmp_mode_i) != 4'b1011)
    |-> $stable(count_o));

  p_match_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flag_o) && !$past(wr_en_i) && $past(cmp_mode_i) == 4'b1011
     && $past(count_o) == $past(cmp_val_i) && $past(count_o) != {W{1'b1}})
    |-> !flag_o);

  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    conv_start_o |=> !conv_start_o);

  p_pulse_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && conv_start_o) |-> ($past(conv_en_i) && $past(cmp_mode_i) == 4'b1011));

  p_write_loads_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en_i)) |-> count_o == $past(wr_data_i));
endmodule

bind period_timer period_timer_chk #(.W(W), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .run_i(run_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .cmp_val_i(cmp_val_i), .cmp_mode_i(cmp_mode_i), .conv_en_i(conv_en_i),
  .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .conv_start_o(conv_start_o)
);

// File: tb/sim_period_timer.sv
`timescale 1ns/1ps
module sim_period_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 0, run_i = 0, wr_en_i = 0, conv_en_i = 0, irq_en_i = 0, flag_clr_i = 0;
  logic [1:0]  psc_sel_i = 0;
  logic [15:0] wr_data_i = 0, cmp_val_i = 0;
  logic [3:0]  cmp_mode_i = 0;
  logic [15:0] count_o;
  logic        flag_o, irq_o, conv_start_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  period_timer u0 (.*);

  // {prescale code, ticks applied, expected count}
  localparam logic [25:0] VEC [0:6] = '{
    {2'b00, 8'd5,  16'd5},
    {2'b01, 8'd5,  16'd2},
    {2'b01, 8'd8,  16'd4},
    {2'b10, 8'd9,  16'd2},
    {2'b10, 8'd3,  16'd0},
    {2'b11, 8'd17, 16'd2},
    {2'b11, 8'd7,  16'd0}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    wr_en_i = 1; wr_data_i = v;
    step();
    wr_en_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int pulses;
    step(); step();
    chk("R1 count in reset", 32'(count_o), 0);
    chk("R1 flag in reset", 32'(flag_o), 0);
    rst = 0;
    step();
    chk("R1 count", 32'(count_o), 0);
    chk("R1 irq/start", {30'd0, irq_o, conv_start_o}, 0);

    // table walk: prescale division (R5, R2)
    foreach (VEC[i]) begin
      psc_sel_i = VEC[i][25:24];
      load(16'h0000);
      run_i = 1; tick_i = 1;
      for (int k = 0; k < int'(VEC[i][23:16]); k++) step();
      tick_i = 0; run_i = 0;
      chk("R5 prescale vector", 32'(count_o), 32'(VEC[i][15:0]));
    end
    psc_sel_i = 0;

    // wrap and flag (R2, R3, R4)
    irq_en_i = 1;
    load(16'hFFFE);
    run_i = 1; tick_i = 1;
    step();
    chk("R2 reach top", 32'(count_o), 32'hFFFF);
    chk("R3 no flag before wrap", 32'(flag_o), 0);
    step();
    tick_i = 0;
    chk("R2 wrap to zero", 32'(count_o), 0);
    chk("R3 flag on wrap edge", 32'(flag_o), 1);
    chk("R4 irq with enable", 32'(irq_o), 1);
    step(); step(); step();
    chk("R3 flag sticky", 32'(flag_o), 1);
    irq_en_i = 0; step();
    chk("R4 irq masked", 32'(irq_o), 0);
    irq_en_i = 1; step();
    chk("R4 irq unmasked", 32'(irq_o), 1);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    chk("R3 flag cleared", 32'(flag_o), 0);
    chk("R4 irq follows clear", 32'(irq_o), 0);
    load(16'hFFFF);
    tick_i = 1; flag_clr_i = 1; step();
    tick_i = 0; flag_clr_i = 0;
    chk("R3 set beats clear", 32'(flag_o), 1);
    flag_clr_i = 1; step(); flag_clr_i = 0;
    irq_en_i = 0;

    // stopped counter (R6, R11)
    load(16'h0042);
    run_i = 0; tick_i = 1;
    step(); step(); step(); step();
    chk("R6 hold while stopped", 32'(count_o), 32'h0042);
    load(16'h0050);
    chk("R6 write while stopped", 32'(count_o), 32'h0050);
    run_i = 1;
    wr_en_i = 1; wr_data_i = 16'h0300; step(); wr_en_i = 0;
    chk("R11 write beats increment", 32'(count_o), 32'h0300);

    // prescale restart on write (R5)
    psc_sel_i = 2'b11;
    step(); step(); step(); step(); step();
    wr_en_i = 1; wr_data_i = 16'h0100; step(); wr_en_i = 0;
    for (int k = 0; k < 7; k++) step();
    chk("R5 restart phase 7 ticks", 32'(count_o), 32'h0100);
    step();
    chk("R5 restart phase 8 ticks", 32'(count_o), 32'h0101);
    tick_i = 0; run_i = 0; psc_sel_i = 0;

    // period clear (R7, R9)
    cmp_val_i = 16'd5; cmp_mode_i = 4'b1011; conv_en_i = 1;
    load(16'h0000);
    run_i = 1; tick_i = 1;
    for (int k = 0; k < 5; k++) step();
    chk("R7 reaches compare", 32'(count_o), 5);
    chk("R9 no early pulse", 32'(conv_start_o), 0);
    step();
    chk("R7 cleared", 32'(count_o), 0);
    chk("R9 pulse on clear edge", 32'(conv_start_o), 1);
    chk("R7 no flag from clear", 32'(flag_o), 0);
    step();
    chk("R9 pulse one cycle", 32'(conv_start_o), 0);
    chk("R7 restarts counting", 32'(count_o), 1);
    for (int k = 0; k < 5; k++) step();
    chk("R7 second period", {15'd0, conv_start_o, count_o}, 32'h0001_0000);
    tick_i = 0;

    // other mode: no clear (R8)
    cmp_mode_i = 4'b0000;
    load(16'h0000);
    tick_i = 1;
    for (int k = 0; k < 6; k++) step();
    tick_i = 0;
    chk("R8 no clear outside mode", 32'(count_o), 6);

    // converter disabled (R9)
    cmp_mode_i = 4'b1011; conv_en_i = 0;
    load(16'h0000);
    tick_i = 1;
    pulses = 0;
    for (int k = 0; k < 6; k++) begin step(); pulses += int'(conv_start_o); end
    tick_i = 0;
    chk("R9 clear without converter enable", 32'(count_o), 0);
    chk("R9 no pulse when disabled", 32'(pulses), 0);

    // write meets match clear (R10)
    conv_en_i = 1;
    load(16'h0000);
    tick_i = 1;
    for (int k = 0; k < 5; k++) step();
    wr_en_i = 1; wr_data_i = 16'h1234; step(); wr_en_i = 0; tick_i = 0;
    chk("R10 write beats clear", 32'(count_o), 32'h1234);
    chk("R10 pulse still issued", 32'(conv_start_o), 1);

    // parked at compare: single pulse (R9)
    cmp_mode_i = 4'b0000;
    load(16'h0007);
    cmp_val_i = 16'd0; cmp_mode_i = 4'b1011; run_i = 0;
    load(16'h0000);
    pulses = 0;
    for (int k = 0; k < 10; k++) begin step(); pulses += int'(conv_start_o); end
    chk("R9 parked no retrigger", 32'(pulses), 1);
    chk("R9 parked count", 32'(count_o), 0);

    finish_run();
  end
endmodule